// File: doc/BRIEF.md
# Isochronous Transmit Sequencer for a Data-Mover Port

This block runs the external data-mover side of a serial-bus link layer when it transmits isochronous packets with automatic header insertion. A rising edge on the ready input starts one bus cycle, and the done output drops on the next clock. For each programmed channel the sequencer asks the link core to send a stored header. The header address starts at 0x38 and steps by four bytes per channel. The link core fetches that header and acknowledges it. The sequencer then gives a one-cycle preamble pulse and pulls the channel's payload from the 16-bit data-mover bus, one quadlet at a time.

Each quadlet is built from two 16-bit halves, high half first, while the read/write strobe is held high. The assembled quadlets are handed to the link core. After the last channel, the sequencer waits for a subaction-gap indication and then raises done again. The three-bit mode input is decoded, and any mode other than isochronous transmit with automatic header insertion leaves the block idle.

Top module: `iso_tx_seq`

## Requirements
- R1: Mode encoding on mode_i: bit 2 = receive, bit 1 = asynchronous, bit 0 = header supplied by the port (no automatic insertion). Only the value 3'b000 starts a cycle. Any other value leaves the block idle with done_o high, even when ready_i rises.
- R2: In idle, done_o is high. A low-to-high change of ready_i seen at a clock edge in idle, with mode 3'b000, starts a cycle. done_o is low after that same edge and stays low until completion.
- R3: hdr_req_o stays high, with hdr_addr_o = 0x38 + 4*c for channel c (counted from 0), until hdr_ack_i is seen high. hdr_ack_i has no effect at any other time.
- R4: After a header acknowledge for a channel whose payload length is non-zero, pre_o is high for exactly one cycle. rw_o rises in the cycle right after it.
- R5: payload_len_i (in quadlets) is sampled with the header acknowledge. rw_o is then high for exactly 2*len consecutive cycles, and each of those cycles takes one 16-bit half from dm_data_i, high half first. One cycle after each low half, quad_vld_o pulses with quad_o = {high half, low half}. rw_o is low at all other times.
- R6: The programmed channel count chan_cnt_i is sampled at start. A value of 0 runs one channel and any value above 4 runs four. After the last quadlet of a channel that is not the final one, the next cycle requests the next header.
- R7: A channel whose sampled length is 0 produces no preamble and no strobe. The next cycle moves on to the next header, or to the gap wait if it was the final channel.
- R8: After the final channel, the block waits with every output low until gap_i is seen high. done_o is high after that edge. gap_i has no effect at any other time.
- R9: Changes of ready_i while a cycle is in progress are ignored. If ready_i is held high through completion, no new cycle starts.
- R10: During and after reset, done_o is high and hdr_req_o, pre_o, rw_o and quad_vld_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data-mover clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode (receive, asynchronous, header-supplied bits) |
| ready_i | input | 1 | Start request; its rising edge starts a cycle |
| chan_cnt_i | input | 3 | Programmed number of channels |
| payload_len_i | input | 8 | Payload length of the current channel, in quadlets |
| hdr_req_o | output | 1 | Request to the link core to transmit a header |
| hdr_addr_o | output | 8 | Byte offset of the header register to send |
| hdr_ack_i | input | 1 | Link core has fetched the header |
| pre_o | output | 1 | One-cycle preamble before the payload |
| rw_o | output | 1 | Read/write strobe, high while payload halves are taken |
| dm_data_i | input | 16 | Data-mover bus |
| quad_o | output | 32 | Assembled payload quadlet |
| quad_vld_o | output | 1 | quad_o is valid in this cycle |
| gap_i | input | 1 | Subaction gap detected |
| done_o | output | 1 | Cycle complete or idle |

## Verification
A wrong internal state shows up quickly at the ports, and the bench compares every output on every clock. A mis-stepped channel index shows as a wrong header offset in the first cycle of the next request. A swapped half or a dropped half shows as a wrong quad_o, or as a missing quad_vld_o, one cycle after the low half. A miscounted length or channel count moves the fall of rw_o, or the return to the gap wait, by at least one cycle. Ready edges, acknowledges and gap pulses are driven in phases where they must be ignored, so any reaction to them changes an output in the following cycle.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PRE,
    ST_FETCH,
    ST_GAP
  } seq_st_e;

  // bit2 receive, bit1 asynchronous, bit0 header supplied by port
  localparam logic [2:0] MODE_ISO_TX_AUTO = 3'b000;
endpackage

// File: rtl/iso_tx_ctrl.sv
module iso_tx_ctrl
  import iso_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       ready_i,
  input  logic       hdr_ack_i,
  input  logic       gap_i,
  input  logic       len_zero_i,
  input  logic       last_quad_i,
  input  logic       last_chan_i,
  output logic       start_o,
  output logic       hdr_take_o,
  output logic       chan_adv_o,
  output logic       fetch_o,
  output logic       hdr_req_o,
  output logic       pre_o,
  output logic       done_o
);
  seq_st_e st_q, st_d;
  logic    ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ready_q <= ready_i;
    end
  end

  assign start_o    = (st_q == ST_IDLE) && ready_i && !ready_q && (mode_i == MODE_ISO_TX_AUTO);
  assign hdr_take_o = (st_q == ST_HDR) && hdr_ack_i;

  always_comb begin
    st_d       = st_q;
    chan_adv_o = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start_o) st_d = ST_HDR;
      ST_HDR: begin
        if (hdr_ack_i) begin
          if (!len_zero_i) st_d = ST_PRE;
          else if (last_chan_i) st_d = ST_GAP;
          else begin
            st_d       = ST_HDR;
            chan_adv_o = 1'b1;
          end
        end
      end
      ST_PRE:   st_d = ST_FETCH;
      ST_FETCH: begin
        if (last_quad_i) begin
          if (last_chan_i) st_d = ST_GAP;
          else begin
            st_d       = ST_HDR;
            chan_adv_o = 1'b1;
          end
        end
      end
      ST_GAP:   if (gap_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign done_o    = (st_q == ST_IDLE);
  assign hdr_req_o = (st_q == ST_HDR);
  assign pre_o     = (st_q == ST_PRE);
  assign fetch_o   = (st_q == ST_FETCH);

  AST_DONE_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !done_o); // R2
  AST_PRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_o |=> !pre_o); // R4
  AST_PRE_TO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_o |=> fetch_o); // R4
  AST_DONE_NEEDS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(gap_i)); // R8
  AST_NO_RESTART_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && ready_i && !ready_q) |=> !done_o || $past(gap_i)); // R9
endmodule

// File: rtl/iso_tx_hdr_sel.sv
module iso_tx_hdr_sel #(
  parameter int MAX_CH = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HDR_BASE   = 8'h38,
  parameter logic [ADDR_W-1:0] HDR_STRIDE = 8'h04,
  localparam int CNT_W = $clog2(MAX_CH + 1),
  localparam int IDX_W = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              chan_adv_i,
  input  logic [CNT_W-1:0]  chan_cnt_i,
  output logic [ADDR_W-1:0] hdr_addr_o,
  output logic              last_chan_o
);
  logic [CNT_W-1:0] n_q, n_clamp;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    if (chan_cnt_i == '0) n_clamp = CNT_W'(1);
    else if (chan_cnt_i > CNT_W'(MAX_CH)) n_clamp = CNT_W'(MAX_CH);
    else n_clamp = chan_cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= CNT_W'(1);
      idx_q <= '0;
    end else if (start_i) begin
      n_q   <= n_clamp;
      idx_q <= '0;
    end else if (chan_adv_i) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign last_chan_o = (CNT_W'(idx_q) == n_q - CNT_W'(1));
  assign hdr_addr_o  = HDR_BASE + ADDR_W'(idx_q) * HDR_STRIDE;

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(idx_q) < n_q); // R6
  AST_NO_ADV_PAST_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_adv_i |-> !last_chan_o); // R6
endmodule

// File: rtl/iso_tx_quad_pack.sv
module iso_tx_quad_pack #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  localparam int QUAD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_take_i,
  input  logic              fetch_i,
  input  logic [LEN_W-1:0]  payload_len_i,
  input  logic [DATA_W-1:0] dm_data_i,
  output logic              len_zero_o,
  output logic              last_quad_o,
  output logic [QUAD_W-1:0] quad_o,
  output logic              quad_vld_o
);
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic              half_q;
  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q      <= '0;
      cnt_q      <= '0;
      half_q     <= 1'b0;
      hi_q       <= '0;
      quad_o     <= '0;
      quad_vld_o <= 1'b0;
    end else begin
      quad_vld_o <= fetch_i && half_q;
      if (hdr_take_i) begin
        len_q  <= payload_len_i;
        cnt_q  <= '0;
        half_q <= 1'b0;
      end else if (fetch_i) begin
        half_q <= !half_q;
        if (!half_q) hi_q <= dm_data_i;
        else begin
          quad_o <= {hi_q, dm_data_i};
          cnt_q  <= cnt_q + LEN_W'(1);
        end
      end
    end
  end

  assign len_zero_o  = (payload_len_i == '0);
  assign last_quad_o = fetch_i && half_q && (cnt_q == len_q - LEN_W'(1));

  AST_VLD_AFTER_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_vld_o |-> $past(fetch_i)); // R5
  AST_FETCH_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |-> len_q != '0); // R7
endmodule

// File: rtl/iso_tx_seq.sv
module iso_tx_seq #(
  parameter int MAX_CH = 4,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 8,
  localparam int CNT_W  = $clog2(MAX_CH + 1),
  localparam int QUAD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              ready_i,
  input  logic [CNT_W-1:0]  chan_cnt_i,
  input  logic [LEN_W-1:0]  payload_len_i,
  output logic              hdr_req_o,
  output logic [ADDR_W-1:0] hdr_addr_o,
  input  logic              hdr_ack_i,
  output logic              pre_o,
  output logic              rw_o,
  input  logic [DATA_W-1:0] dm_data_i,
  output logic [QUAD_W-1:0] quad_o,
  output logic              quad_vld_o,
  input  logic              gap_i,
  output logic              done_o
);
  logic start, hdr_take, chan_adv, fetch;
  logic len_zero, last_quad, last_chan;

  iso_tx_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .ready_i     (ready_i),
    .hdr_ack_i   (hdr_ack_i),
    .gap_i       (gap_i),
    .len_zero_i  (len_zero),
    .last_quad_i (last_quad),
    .last_chan_i (last_chan),
    .start_o     (start),
    .hdr_take_o  (hdr_take),
    .chan_adv_o  (chan_adv),
    .fetch_o     (fetch),
    .hdr_req_o   (hdr_req_o),
    .pre_o       (pre_o),
    .done_o      (done_o)
  );

  iso_tx_hdr_sel #(.MAX_CH(MAX_CH), .ADDR_W(ADDR_W)) u_hdr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .chan_adv_i  (chan_adv),
    .chan_cnt_i  (chan_cnt_i),
    .hdr_addr_o  (hdr_addr_o),
    .last_chan_o (last_chan)
  );

  iso_tx_quad_pack #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_pack (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hdr_take_i    (hdr_take),
    .fetch_i       (fetch),
    .payload_len_i (payload_len_i),
    .dm_data_i     (dm_data_i),
    .len_zero_o    (len_zero),
    .last_quad_o   (last_quad),
    .quad_o        (quad_o),
    .quad_vld_o    (quad_vld_o)
  );

  assign rw_o = fetch;

  AST_RW_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_o |-> !hdr_req_o && !done_o && !pre_o); // R5
  AST_REQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_req_o && !hdr_ack_i) |=> hdr_req_o && $stable(hdr_addr_o)); // R3
  AST_IDLE_IF_OTHER_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_i != 3'b000) |=> done_o); // R1
endmodule

// File: tb/iso_tx_seq_tb_top.sv
module iso_tx_seq_tb_top;
  typedef struct {
    logic        ready, ack, gap;
    logic [2:0]  mode, cnt;
    logic [7:0]  len;
    logic [15:0] data;
    logic        e_done, e_req, e_pre, e_rw, e_vld;
    logic [7:0]  e_addr;
    logic [31:0] e_quad;
    string       tag;
  } step_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  mode = '0, cnt = '0;
  logic        ready = 1'b0, ack = 1'b0, gap = 1'b0;
  logic [7:0]  len = '0;
  logic [15:0] data = '0;
  logic        hdr_req, pre, rw, qvld, done;
  logic [7:0]  addr;
  logic [31:0] quad;
  int checks = 0, errors = 0;
  bit finished = 0;
  step_t q[$];

  always #5 clk = ~clk;

  iso_tx_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ready_i(ready),
    .chan_cnt_i(cnt), .payload_len_i(len), .hdr_req_o(hdr_req),
    .hdr_addr_o(addr), .hdr_ack_i(ack), .pre_o(pre), .rw_o(rw),
    .dm_data_i(data), .quad_o(quad), .quad_vld_o(qvld), .gap_i(gap),
    .done_o(done)
  );

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  // Expected outputs per phase
  function automatic step_t st(logic r, logic a, logic g, logic [2:0] m, logic [2:0] c,
                               logic [7:0] l, logic [15:0] d, string tag);
    step_t s;
    s.ready = r; s.ack = a; s.gap = g; s.mode = m; s.cnt = c; s.len = l; s.data = d;
    s.e_done = 0; s.e_req = 0; s.e_pre = 0; s.e_rw = 0; s.e_vld = 0;
    s.e_addr = 8'h38; s.e_quad = '0; s.tag = tag;
    return s;
  endfunction

  task automatic run_q();
    while (q.size() > 0) begin
      step_t s = q.pop_front();
      ready = s.ready; ack = s.ack; gap = s.gap; mode = s.mode;
      cnt = s.cnt; len = s.len; data = s.data;
      @(negedge clk);
      chk(s.tag, "done_o", 32'(done), 32'(s.e_done));
      chk(s.tag, "hdr_req_o", 32'(hdr_req), 32'(s.e_req));
      if (s.e_req) chk(s.tag, "hdr_addr_o", 32'(addr), 32'(s.e_addr));
      chk(s.tag, "pre_o", 32'(pre), 32'(s.e_pre));
      chk(s.tag, "rw_o", 32'(rw), 32'(s.e_rw));
      chk(s.tag, "quad_vld_o", 32'(qvld), 32'(s.e_vld));
      if (s.e_vld) chk(s.tag, "quad_o", quad, s.e_quad);
    end
  endtask

  task automatic scen(int n_prog, int l0, int l1, int l2, int l3,
                      int ack_dly, int gap_dly, bit noise, int seed);
    int lens[4] = '{l0, l1, l2, l3};
    int n = (n_prog == 0) ? 1 : (n_prog > 4 ? 4 : n_prog);
    logic [2:0] c3 = 3'(n_prog);
    logic r = 1'b1;
    logic [15:0] prev = '0;
    step_t s;
    s = st(0, 0, 0, 0, c3, 8'(lens[0]), 0, "R2"); s.e_done = 1; q.push_back(s);
    s = st(1, 0, 0, 0, c3, 8'(lens[0]), 0, "R2"); s.e_req = 1; q.push_back(s);
    for (int c = 0; c < n; c++) begin
      logic [7:0] a = 8'(8'h38 + 4 * c);
      logic [7:0] an = 8'(8'h38 + 4 * (c + 1));
      bit last_ch = (c == n - 1);
      for (int k = 0; k < ack_dly; k++) begin
        if (noise) r = ~r;
        s = st(r, 0, noise, 0, c3, 8'(lens[c]), 16'hdead, noise ? "R9" : "R3");
        s.e_req = 1; s.e_addr = a; q.push_back(s);
      end
      s = st(r, 1, 0, 0, c3, 8'(lens[c]), 0, c == 0 ? "R3" : "R6");
      if (lens[c] == 0) begin
        s.tag = "R7";
        if (!last_ch) begin s.e_req = 1; s.e_addr = an; end
        q.push_back(s);
        continue;
      end
      s.e_pre = 1; q.push_back(s);
      s = st(r, noise, 0, 0, c3, 8'(lens[c]), 0, "R4"); s.e_rw = 1; q.push_back(s);
      for (int j = 0; j < 2 * lens[c]; j++) begin
        logic [15:0] d = 16'(seed * 977 + c * 131 + j * 29 + 16'h1357);
        bit last = (j == 2 * lens[c] - 1);
        if (noise) r = ~r;
        s = st(r, noise, noise, 0, c3, 8'd0, d, "R5");
        s.e_rw = !last;
        if (j % 2 == 1) begin s.e_vld = 1; s.e_quad = {prev, d}; end
        if (last && !last_ch) begin s.e_req = 1; s.e_addr = an; s.tag = "R6"; end
        prev = d;
        q.push_back(s);
      end
    end
    for (int k = 0; k < gap_dly; k++) begin
      if (noise) r = ~r;
      s = st(r, noise, 0, 0, c3, 0, 0, "R8"); q.push_back(s);
    end
    s = st(1, 0, 1, 0, c3, 0, 0, "R8"); s.e_done = 1; q.push_back(s);
    for (int k = 0; k < 3; k++) begin
      s = st(1, 0, 0, 0, c3, 0, 0, "R9"); s.e_done = 1; q.push_back(s);
    end
    run_q();
  endtask

  task automatic mode_scen(logic [2:0] m);
    step_t s;
    s = st(0, 0, 0, m, 3'd1, 8'd1, 0, "R1"); s.e_done = 1; q.push_back(s);
    for (int k = 0; k < 3; k++) begin
      s = st(1, k == 1, k == 2, m, 3'd1, 8'd1, 0, "R1"); s.e_done = 1; q.push_back(s);
    end
    run_q();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state while held and right after release
    chk("R10", "done_o", 32'(done), 1);
    chk("R10", "busy outputs", 32'({hdr_req, pre, rw, qvld}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "done_o", 32'(done), 1);
    chk("R10", "busy outputs", 32'({hdr_req, pre, rw, qvld}), 0);
    scen(1, 3, 0, 0, 0, 0, 2, 0, 1);
    scen(3, 2, 1, 4, 0, 2, 0, 1, 2);
    scen(0, 1, 0, 0, 0, 1, 1, 0, 3);   // count 0 runs one channel (R6)
    scen(6, 1, 0, 2, 1, 0, 3, 1, 4);   // count above 4 clamps (R6), zero length (R7)
    scen(2, 0, 0, 0, 0, 1, 0, 0, 5);   // all zero lengths (R7)
    scen(4, 2, 2, 1, 3, 3, 1, 1, 6);
    for (int m = 1; m < 8; m++) mode_scen(3'(m));
    scen(2, 1, 2, 0, 0, 0, 0, 0, 7);   // normal mode still works afterwards (R1)
    finish_run();
  end
endmodule